// File: doc/BRIEF.md
# Watchdog Timer with External Reset Drive

This block guards a processor against runaway code. It counts an externally prescaled tick and, once the count reaches a terminal value chosen by software, asks for a reset of the whole chip. The request is a pulse of fixed length. The same pulse can also turn on the output enable of an open-drain reset pin, so that external peripherals are reset together with the chip. Software that is running normally keeps the timer from expiring by writing a clear key to the command register.

The timer comes out of reset already counting. Two register writes in a fixed order switch it off. First, software writes a disable key to the command register. Then it writes the master register with its enable bit at 0. A clear key written between these two writes cancels the pending disable. Any command value other than the two keys does nothing.

Both registers sit on a simple synchronous write bus. The master register can also be read back combinationally.

Top module: `wdt_guard`

## Requirements
- R1: After reset the timer is armed, the period select is 3, the drive bit is 0, the count is 0, and both `chipRstReq` and `extRstOe` are low. Reading the master address returns 0x07.
- R2: While armed and outside a reset pulse, the count advances by one on each clock edge where `tick` is 1, and it holds on edges where `tick` is 0.
- R3: Master register layout is bit 0 = enable, bits 2:1 = period select, bit 3 = drive. Select value s gives a terminal count of 2^(BASE_LOG2+2s) ticks. `chipRstReq` rises on the edge that would carry the count past its terminal value, so it rises exactly that many ticks after the count was last zeroed.
- R4: Writing 0x4E to the command address sets the count to 0. This takes priority over a timeout due on the same edge.
- R5: `chipRstReq` stays high for exactly PULSE_LEN cycles. The count is held at 0 during the pulse and starts again from 0 once the pulse ends.
- R6: `extRstOe` is high on exactly the cycles where `chipRstReq` is high, and only if the drive bit was 1 at the timeout edge. Otherwise it stays low.
- R7: Writing 0xB1 to the command address arms a pending disable. A later master write with bit 0 = 0 then disarms the timer, and no reset is requested while it is disarmed. A master write with bit 0 = 0 and no pending disable leaves the timer armed, although the period and drive fields are still updated.
- R8: A clear key written after the disable key and before the master write cancels the pending disable.
- R9: A command write of any value other than 0x4E or 0xB1 changes neither the count nor the pending disable.
- R10: A master write with bit 0 = 1 re-arms a disarmed timer, and counting restarts from 0.
- R11: A read at the master address returns the enable, period and drive bits in their write positions, with all other bits 0. A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data |
| tick | input | 1 | Prescaled count enable |
| chipRstReq | output | 1 | Chip-wide reset request pulse |
| extRstOe | output | 1 | Output enable for the open-drain reset pin driver |

## Verification
The bench sweeps every period select against both drive settings and times each timeout to the exact cycle. A comparison that is off by one, or an exponent step that is wrong, therefore shows up as a wrong latency. It also times the restart after each pulse, which catches a counter that keeps running during the pulse or a pulse of the wrong width. It writes every non-key value to the command register and then tries a disable without the key. A decoder that is too loose would either shift the next timeout or silently disarm the timer. Finally, it places a clear key on the very edge of an imminent timeout and between the two disable writes, and also pauses `tick`. A design with the wrong priority fires a reset that should not happen, keeps a pending disable that should have been cancelled, or counts ticks that never arrived.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Strobes and levels passed from register control to the counting datapath
  typedef struct packed {
    logic       clearCnt;   // clear key seen this cycle
    logic       run;        // timer armed
    logic [1:0] periodSel;  // terminal count select
    logic       extDrive;   // drive external reset on timeout
  } wdt_ctrl_t;

endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h11,
  parameter logic [DATA_W-1:0] CLEAR_KEY   = 'h4E,
  parameter logic [DATA_W-1:0] DISABLE_KEY = 'hB1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output wdt_ctrl_t         ctrlBus
);

  logic       armed;
  logic       pendingOff;
  logic [1:0] periodSel;
  logic       extDrive;

  logic masterWr, cmdWr, clearHit, offHit;

  assign masterWr = wrEn && (addr == MASTER_ADDR);
  assign cmdWr    = wrEn && (addr == CMD_ADDR);
  assign clearHit = cmdWr && (wrData == CLEAR_KEY);
  assign offHit   = cmdWr && (wrData == DISABLE_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b1;
      pendingOff <= 1'b0;
      periodSel  <= 2'b11;
      extDrive   <= 1'b0;
    end else begin
      if (masterWr) begin
        periodSel <= wrData[2:1];
        extDrive  <= wrData[3];
        if (wrData[0]) begin
          armed <= 1'b1;
        end else if (pendingOff) begin
          armed      <= 1'b0;
          pendingOff <= 1'b0;
        end
      end
      if (clearHit) begin
        pendingOff <= 1'b0;
      end else if (offHit) begin
        pendingOff <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == MASTER_ADDR) begin
      rdData[3:0] = {extDrive, periodSel, armed};
    end
  end

  always_comb begin
    ctrlBus.clearCnt  = clearHit;
    ctrlBus.run       = armed;
    ctrlBus.periodSel = periodSel;
    ctrlBus.extDrive  = extDrive;
  end

endmodule

// File: rtl/wdt_guard_datapath.sv
module wdt_guard_datapath
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 16,
  parameter int PULSE_LEN = 16,
  localparam int CNT_W = BASE_LOG2 + 6,
  localparam int PW    = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  wdt_ctrl_t        ctrlBus,
  output logic [CNT_W-1:0] cntVal,
  output logic             chipRstReq,
  output logic             extRstOe
);

  logic [CNT_W-1:0] lastTab [4];
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pulseCnt;
  logic             driveHold;
  logic             pulseActive;
  logic             timeout;

  // Last count value before expiry, one entry per period select
  for (genvar g = 0; g < 4; g++) begin : gen_last
    assign lastTab[g] = CNT_W'((64'(1) << (BASE_LOG2 + 2 * g)) - 64'(1));
  end

  assign pulseActive = (pulseCnt != '0);
  assign timeout = ctrlBus.run && tick && !pulseActive && !ctrlBus.clearCnt
                   && (cnt >= lastTab[ctrlBus.periodSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrlBus.clearCnt || !ctrlBus.run || pulseActive || timeout) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt  <= '0;
      driveHold <= 1'b0;
    end else if (timeout) begin
      pulseCnt  <= PW'(PULSE_LEN);
      driveHold <= ctrlBus.extDrive;
    end else if (pulseActive) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign cntVal     = cnt;
  assign chipRstReq = pulseActive;
  assign extRstOe   = pulseActive && driveHold;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h11,
  parameter logic [DATA_W-1:0] CLEAR_KEY   = 'h4E,
  parameter logic [DATA_W-1:0] DISABLE_KEY = 'hB1,
  parameter int BASE_LOG2 = 16,
  parameter int PULSE_LEN = 16,
  localparam int CNT_W = BASE_LOG2 + 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  output logic              chipRstReq,
  output logic              extRstOe
);

  wdt_ctrl_t        ctrlBus;
  logic [CNT_W-1:0] cntVal;

  wdt_guard_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASTER_ADDR(MASTER_ADDR), .CMD_ADDR(CMD_ADDR),
    .CLEAR_KEY(CLEAR_KEY), .DISABLE_KEY(DISABLE_KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ctrlBus(ctrlBus)
  );

  wdt_guard_datapath #(
    .BASE_LOG2(BASE_LOG2), .PULSE_LEN(PULSE_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrlBus(ctrlBus),
    .cntVal(cntVal), .chipRstReq(chipRstReq), .extRstOe(extRstOe)
  );

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h11,
  parameter logic [DATA_W-1:0] CLEAR_KEY   = 'h4E,
  parameter int CNT_W     = 22,
  parameter int PULSE_LEN = 16,
  localparam int HW = $clog2(PULSE_LEN + 1) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              chipRstReq,
  input logic              extRstOe
);

  logic [HW-1:0] hiCnt;
  logic          firstDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt     <= '0;
      firstDone <= 1'b0;
    end else begin
      firstDone <= 1'b1;
      hiCnt     <= chipRstReq ? hiCnt + 1'b1 : '0;
    end
  end

  AST_ARMED_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    !firstDone |-> (run && cnt == '0 && !chipRstReq));  // R1

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CMD_ADDR && wrData == CLEAR_KEY) |=> (cnt == '0));  // R4

  AST_PULSE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    chipRstReq |-> (cnt == '0));  // R5

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    chipRstReq |-> (hiCnt < HW'(PULSE_LEN)));  // R5

  AST_OE_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    extRstOe |-> chipRstReq);  // R6

  AST_OE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (chipRstReq && $past(chipRstReq)) |-> $stable(extRstOe));  // R6

  AST_OFF_BY_MASTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |-> $past(wrEn && addr == MASTER_ADDR && !wrData[0]));  // R7

  AST_IDLE_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !$rose(chipRstReq));  // R7

endmodule

bind wdt_guard wdt_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MASTER_ADDR(MASTER_ADDR), .CMD_ADDR(CMD_ADDR), .CLEAR_KEY(CLEAR_KEY),
  .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .run(ctrlBus.run), .cnt(cntVal), .chipRstReq(chipRstReq), .extRstOe(extRstOe)
);

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;

  localparam int BASE = 4;
  localparam int PLEN = 16;
  localparam logic [7:0] MADDR = 8'h10;
  localparam logic [7:0] CADDR = 8'h11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       tick = 1'b1;
  logic       chipRstReq, extRstOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_guard #(.BASE_LOG2(BASE), .PULSE_LEN(PLEN)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .chipRstReq(chipRstReq), .extRstOe(extRstOe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic readReg(input logic [7:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic measure(output int n, input int limit);
    n = 0;
    while (!chipRstReq && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulseCheck(input string req, input bit expDrive);
    int w = 0;
    bit oeOk = 1'b1;
    while (chipRstReq && w < 4 * PLEN) begin
      if (extRstOe !== expDrive) oeOk = 1'b0;
      @(negedge clk);
      w++;
    end
    check(w == PLEN, req, "pulse width", w, PLEN);
    check(oeOk && extRstOe == 1'b0, req, "extRstOe follows drive", int'(oeOk), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, v, term, hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R11: reset state
    check(chipRstReq == 1'b0 && extRstOe == 1'b0, "R1", "outputs after reset", int'(chipRstReq), 0);
    readReg(MADDR, v);
    check(v == 8'h07, "R1", "master readback after reset", v, 7);
    readReg(8'h22, v);
    check(v == 0, "R11", "unmapped read", v, 0);
    readReg(CADDR, v);
    check(v == 0, "R11", "command read", v, 0);
    measure(n, 3000);
    check(n == (1 << (BASE + 6)), "R1", "default timeout latency", n, 1 << (BASE + 6));
    pulseCheck("R6", 1'b0);

    // R3 / R5 / R6 / R11: sweep period select and drive bit
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        term = 1 << (BASE + 2 * s);
        busWr(MADDR, 8'((d << 3) | (s << 1) | 1));
        readReg(MADDR, v);
        check(v == ((d << 3) | (s << 1) | 1), "R11", "master readback", v, (d << 3) | (s << 1) | 1);
        busWr(CADDR, 8'h4E);
        measure(n, term + 50);
        check(n == term, "R3", "timeout latency", n, term);
        pulseCheck("R6", d[0]);
        measure(n, term + 50);
        check(n == term, "R5", "restart after pulse", n, term);
        pulseCheck("R5", d[0]);
      end
    end

    // R2: tick low holds the count
    busWr(MADDR, 8'h01);
    busWr(CADDR, 8'h4E);
    tick = 1'b0;
    repeat (10) @(negedge clk);
    tick = 1'b1;
    measure(n, 100);
    check(10 + n == 26, "R2", "latency with paused tick", 10 + n, 26);
    pulseCheck("R2", 1'b0);

    // R4: clear on the edge of a due timeout wins
    busWr(CADDR, 8'h4E);
    repeat (15) @(negedge clk);
    busWr(CADDR, 8'h4E);
    check(chipRstReq == 1'b0, "R4", "no pulse when clear meets timeout", int'(chipRstReq), 0);
    measure(n, 100);
    check(n == 16, "R4", "latency after late clear", n, 16);
    pulseCheck("R4", 1'b0);

    // R9 / R7: every non-key value ignored, disable attempt without key ignored
    busWr(MADDR, 8'h07);
    busWr(CADDR, 8'h4E);
    for (int k = 0; k < 256; k++) begin
      if (k != 8'h4E && k != 8'hB1) busWr(CADDR, 8'(k));
    end
    busWr(MADDR, 8'h06);
    readReg(MADDR, v);
    check(v == 8'h07, "R7", "enable kept without key", v, 7);
    measure(n, 2000);
    check(n == 1024 - 255, "R9", "stray commands left count alone", n, 1024 - 255);
    pulseCheck("R9", 1'b0);

    // R8: clear key cancels pending disable
    busWr(MADDR, 8'h01);
    busWr(CADDR, 8'hB1);
    busWr(CADDR, 8'h4E);
    busWr(MADDR, 8'h00);
    readReg(MADDR, v);
    check(v == 8'h01, "R8", "still armed after cancel", v, 1);
    measure(n, 100);
    check(n == 15, "R8", "timeout after cancelled disable", n, 15);
    pulseCheck("R8", 1'b0);

    // R7: proper disable sequence
    busWr(CADDR, 8'hB1);
    busWr(MADDR, 8'h08);
    readReg(MADDR, v);
    check(v == 8'h08, "R7", "disarmed readback", v, 8);
    hi = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (chipRstReq) hi++;
    end
    check(hi == 0, "R7", "no reset while disarmed", hi, 0);

    // R10: re-arm restarts from zero
    busWr(MADDR, 8'h09);
    measure(n, 100);
    check(n == 16, "R10", "latency after re-arm", n, 16);
    pulseCheck("R10", 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule